// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between an internal single-word request port and an external asynchronous static RAM (32K words of 8 bits by default). A request is taken through a valid/ready handshake. The block then drives the memory's active-low chip select, write enable and output enable, together with the address and a split data bus (out, out-enable, in). Each strobe is held for a number of clock cycles derived from the memory's nanosecond limits. When the access ends, the block returns the read data, or an acknowledge for a write, as a single-cycle response.

Every nanosecond limit is converted to a cycle count with a ceiling division by the clock period parameter, and no count is less than one. A read holds select and output enable low for the longest of the cycle-time, address-access and output-enable-access counts. A write keeps output enable high throughout, so the memory never drives the bus during a write. The block first waits out the memory's output turn-off time with write enable already low, and only then drives data, keeping it stable for the data setup count. The whole write window also covers the write pulse, select-to-end, address-to-end and write cycle limits.

A retention request input parks the memory deselected so that its supply can be lowered. Once the request is released, new accesses stay blocked for one read cycle time.

Top module: `sram_async_ctrl`

## Requirements
- R1: While rst is high and after it falls, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe and rsp_valid are 0, and req_ready is 1 when ret_req is 0.
- R2: A read holds mem_cs_n=0, mem_oe_n=0, mem_we_n=1 for exactly RD cycles, where RD = max(ceil(tRC/T), ceil(tAA/T), ceil(tOE/T)) (7 at T=8 ns), and mem_addr does not change while mem_cs_n is 0.
- R3: Read data is captured from mem_dq_in on the last clock of the read window and returned on rsp_rdata with rsp_valid high for exactly one cycle and rsp_write=0.
- R4: A write holds mem_cs_n=0 and mem_we_n=0 together for exactly max(ceil(tWC/T), HZ+ceil(tDW/T), ceil(tCW/T)) cycles (7 at T=8 ns), with mem_oe_n=1 throughout.
- R5: mem_dq_oe rises only after mem_we_n has been 0 for at least HZ = ceil(tOHZ/T) cycles, mem_dq_out stays stable while driven, it is driven for at least ceil(tDW/T) cycles before the end of the write, and it is still driven in the cycle when the write ends.
- R6: req_ready falls in the cycle after a request is accepted and stays 0 until the cycle of the response, when it is 1 again. One access is in flight at a time.
- R7: When ret_req is high and the controller is idle, ret_ack rises, mem_cs_n stays 1 and req_ready stays 0. An access already in flight finishes first, and its data is kept.
- R8: After ret_req falls, req_ready stays 0 for exactly ceil(tRC/T) cycles (7 at T=8 ns).
- R9: mem_dq_oe is never 1 while mem_oe_n is 0 or while the memory could still be driving the bus.
- R10: A write ends with a one-cycle rsp_valid and rsp_write=1, and a later read of the same address returns the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_rdata | output | DATA_W | Read byte |
| ret_req | input | 1 | Enter data-retention parking |
| ret_ack | output | 1 | Memory parked deselected |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data driven to memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | DATA_W | Data from memory |

## Verification
The bench's memory model returns the inverted byte until the read-access count is reached. A read window one cycle short therefore returns corrupted data instead of passing by chance. The model measures every select window, write-enable overlap, drive-start delay and data-hold cycle. A design that drove the bus too early after a read, cut the write short, or dropped data at the rising edge of write enable would show up at the end of that access. The retention tests count the blocked cycles after release exactly. They also raise the retention request in the middle of a write, so a design that aborted the in-flight access would lose the byte read back afterwards.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  function automatic int ns_to_cyc(input int ns, input int per_ns);
    int c;
    c = (ns + per_ns - 1) / per_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int rest_after(input int total, input int used);
    return (total > used) ? total - used : 1;
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSET,
    ST_WDRV,
    ST_WHOLD
  } ctl_state_t;

  typedef enum logic [1:0] {
    RG_OFF,
    RG_HOLD,
    RG_WAIT
  } ret_state_t;

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_ret_guard.sv
module sram_ret_guard
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int RC_CYC = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic ret_req,
  input  logic ctl_idle,
  output logic block,
  output logic ret_ack
);
  localparam logic [CNT_W-1:0] RC_LD = CNT_W'(RC_CYC - 1);

  ret_state_t st_q;
  logic       tm_load;
  logic       tm_exp;

  assign tm_load = (st_q == RG_HOLD) && !ret_req;

  sram_phase_timer #(.CNT_W(CNT_W)) u_rc_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tm_load),
    .load_val (RC_LD),
    .expired  (tm_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) st_q <= RG_OFF;
    else begin
      case (st_q)
        RG_OFF:  if (ret_req && ctl_idle) st_q <= RG_HOLD;
        RG_HOLD: if (!ret_req) st_q <= RG_WAIT;
        RG_WAIT: begin
          if (ret_req)     st_q <= RG_HOLD;
          else if (tm_exp) st_q <= RG_OFF;
        end
        default: st_q <= RG_OFF;
      endcase
    end
  end

  assign block   = (st_q != RG_OFF);
  assign ret_ack = (st_q == RG_HOLD);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 8,
  parameter int T_RC_NS  = 55,
  parameter int T_AA_NS  = 55,
  parameter int T_OE_NS  = 25,
  parameter int T_WC_NS  = 55,
  parameter int T_WP_NS  = 40,
  parameter int T_CW_NS  = 45,
  parameter int T_AW_NS  = 45,
  parameter int T_DW_NS  = 25,
  parameter int T_OHZ_NS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ret_req,
  output logic              ret_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  // Phase lengths in clock cycles
  localparam int RC_CYC = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int RD_CYC = imax(imax(RC_CYC, ns_to_cyc(T_AA_NS, CLK_NS)),
                               ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int HZ_CYC = ns_to_cyc(T_OHZ_NS, CLK_NS);
  localparam int WD_CYC = imax(
      imax(ns_to_cyc(T_DW_NS, CLK_NS), rest_after(ns_to_cyc(T_WP_NS, CLK_NS), HZ_CYC)),
      imax(imax(rest_after(ns_to_cyc(T_CW_NS, CLK_NS), HZ_CYC),
                rest_after(ns_to_cyc(T_AW_NS, CLK_NS), HZ_CYC)),
           rest_after(ns_to_cyc(T_WC_NS, CLK_NS), HZ_CYC)));
  localparam int MAX_CYC = imax(imax(RD_CYC, HZ_CYC), imax(WD_CYC, RC_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LD = CNT_W'(HZ_CYC - 1);
  localparam logic [CNT_W-1:0] WD_LD = CNT_W'(WD_CYC - 1);

  ctl_state_t        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              cs_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic              rsp_valid_q, rsp_write_q;
  logic              tm_load, tm_exp;
  logic [CNT_W-1:0]  tm_val;
  logic              blocked;
  logic              accept;

  assign req_ready = (st_q == ST_IDLE) && !blocked && !ret_req;
  assign accept    = req_valid && req_ready;

  sram_ret_guard #(.CNT_W(CNT_W), .RC_CYC(RC_CYC)) u_guard (
    .clk      (clk),
    .rst      (rst),
    .ret_req  (ret_req),
    .ctl_idle (st_q == ST_IDLE),
    .block    (blocked),
    .ret_ack  (ret_ack)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (tm_load),
    .load_val (tm_val),
    .expired  (tm_exp)
  );

  always_comb begin
    tm_load = 1'b0;
    tm_val  = RD_LD;
    case (st_q)
      ST_IDLE: if (accept) begin
        tm_load = 1'b1;
        tm_val  = req_write ? HZ_LD : RD_LD;
      end
      ST_WSET: if (tm_exp) begin
        tm_load = 1'b1;
        tm_val  = WD_LD;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      cs_n_q      <= 1'b1;
      we_n_q      <= 1'b1;
      oe_n_q      <= 1'b1;
      dq_oe_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_write_q <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          cs_n_q  <= 1'b0;
          we_n_q  <= !req_write;
          oe_n_q  <= req_write;
          st_q    <= req_write ? ST_WSET : ST_READ;
        end
        ST_READ: if (tm_exp) begin
          rdata_q     <= mem_dq_in;
          cs_n_q      <= 1'b1;
          oe_n_q      <= 1'b1;
          rsp_valid_q <= 1'b1;
          rsp_write_q <= 1'b0;
          st_q        <= ST_IDLE;
        end
        ST_WSET: if (tm_exp) begin
          dq_oe_q <= 1'b1;
          st_q    <= ST_WDRV;
        end
        ST_WDRV: if (tm_exp) begin
          cs_n_q <= 1'b1;
          we_n_q <= 1'b1;
          st_q   <= ST_WHOLD;
        end
        ST_WHOLD: begin
          dq_oe_q     <= 1'b0;
          rsp_valid_q <= 1'b1;
          rsp_write_q <= 1'b1;
          st_q        <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_write  = rsp_write_q;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_cs_n   = cs_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = dq_oe_q;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              ret_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready); // R6
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n && $past(!mem_cs_n) |-> $stable(mem_addr)); // R2
  AST_OE_HIGH_WRITE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n && !mem_cs_n); // R4
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n); // R9
  AST_DRIVE_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> !mem_we_n && $past(!mem_we_n)); // R5
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe && $past(mem_dq_oe) |-> $stable(mem_dq_out)); // R5
  AST_RET_PARKED: assert property (@(posedge clk) disable iff (rst)
    ret_ack |-> mem_cs_n && !req_ready); // R7
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .ret_ack    (ret_ack),
  .mem_addr   (mem_addr),
  .mem_cs_n   (mem_cs_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_async_ctrl_test.sv
`timescale 1ns/1ps
module sram_async_ctrl_test;
  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int PER = 8;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_EXP  = mx(cdiv(55, PER), cdiv(25, PER));
  localparam int HZ_EXP  = cdiv(20, PER);
  localparam int DW_EXP  = cdiv(25, PER);
  localparam int WLO_EXP = mx(cdiv(55, PER), mx(HZ_EXP + DW_EXP, cdiv(45, PER)));
  localparam int RC_EXP  = cdiv(55, PER);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0, ret_req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_write, ret_ack;
  logic [DW-1:0] rsp_rdata, mem_dq_out, dq_model;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;

  always #4 clk = ~clk;

  sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(PER)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_rdata(rsp_rdata),
    .ret_req(ret_req), .ret_ack(ret_ack), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(dq_model)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Behavioural memory with timing checks, sampled at falling edges
  logic [DW-1:0] mem    [256];
  logic [DW-1:0] shadow [256];
  int rd_run, lo_run, wlo, drv, hz_run;
  bit prev_cs_low, prev_drv, acc_wr, oe_low_w, rd_mode;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_dq, wd_last;

  always @(negedge clk) begin
    if (rst) begin
      rd_run = 0; lo_run = 0; wlo = 0; drv = 0; hz_run = 100;
      prev_cs_low = 0; prev_drv = 0; acc_wr = 0; oe_low_w = 0;
      dq_model = '0;
    end else begin
      rd_mode = !mem_cs_n && mem_we_n && !mem_oe_n;
      if (!mem_cs_n && prev_cs_low && mem_addr != prev_addr)
        check(0, "R2 address moved inside access", mem_addr, prev_addr);
      if (!mem_cs_n) begin
        lo_run++;
        if (!mem_we_n) acc_wr = 1;
        if (!mem_we_n && !mem_oe_n) oe_low_w = 1;
      end
      if (mem_dq_oe && !prev_drv)
        check(wlo >= HZ_EXP, "R5 drive start after we low", wlo, HZ_EXP);
      if (mem_dq_oe && prev_drv && mem_dq_out != prev_dq)
        check(0, "R5 write data changed", mem_dq_out, prev_dq);
      if (!mem_cs_n && !mem_we_n) begin
        wlo++;
        if (mem_dq_oe) drv++;
      end
      if (rd_mode) hz_run = 0;
      else if (hz_run < 100) hz_run++;
      if (mem_dq_oe && (!mem_oe_n || hz_run < HZ_EXP))
        check(0, "R9 bus contention", hz_run, HZ_EXP);
      if (mem_cs_n && prev_cs_low) begin
        if (acc_wr) begin
          check(lo_run == WLO_EXP, "R4 write window", lo_run, WLO_EXP);
          check(!oe_low_w, "R4 oe low in write", oe_low_w, 0);
          check(drv >= DW_EXP, "R5 data setup", drv, DW_EXP);
          check(mem_dq_oe, "R5 data hold at end", mem_dq_oe, 1);
          mem[prev_addr] = wd_last;
        end else begin
          check(lo_run == RD_EXP, "R2 read window", lo_run, RD_EXP);
        end
        lo_run = 0; wlo = 0; drv = 0; acc_wr = 0; oe_low_w = 0;
      end
      if (rd_mode) begin
        if (rd_run > 0 && mem_addr != prev_addr) rd_run = 1;
        else rd_run++;
      end else rd_run = 0;
      dq_model = (rd_mode && rd_run >= RD_EXP) ? mem[mem_addr] : ~mem[mem_addr];
      if (mem_dq_oe) wd_last = mem_dq_out;
      prev_cs_low = !mem_cs_n;
      prev_drv    = mem_dq_oe;
      prev_addr   = mem_addr;
      prev_dq     = mem_dq_out;
    end
  end

  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] q);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) begin
      check(!req_ready, "R6 ready low while busy", req_ready, 0);
      @(negedge clk);
    end
    check(req_ready, "R6 ready back at response", req_ready, 1);
    check(rsp_write == w, w ? "R10 write ack kind" : "R3 read rsp kind", rsp_write, w);
    q = rsp_rdata;
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 29 + 7) & 255);
  endfunction

  initial begin
    logic [DW-1:0] q;
    int n;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes idle in reset", {mem_cs_n, mem_we_n, mem_oe_n}, 7);
    check(!mem_dq_oe && !rsp_valid, "R1 no drive/rsp in reset", {mem_dq_oe, rsp_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", req_ready, 1);
    check(mem_cs_n, "R1 deselected after reset", mem_cs_n, 1);

    // Sweep: write every address, then read every address
    for (int a = 0; a < 256; a++) begin
      access(1'b1, AW'(a), pat(a), q);
      shadow[a] = pat(a);
    end
    for (int a = 0; a < 256; a++) begin
      access(1'b0, AW'(a), '0, q);
      check(q == shadow[a], "R3 read data", q, shadow[a]);
    end
    // Back-to-back mixed traffic
    for (int a = 0; a < 256; a++) begin
      logic [DW-1:0] d;
      d = DW'(a) ^ 8'hC3;
      access(1'b1, AW'(a), d, q);
      shadow[a] = d;
      access(1'b0, AW'(a), '0, q);
      check(q == d, "R10 readback after write", q, d);
      access(1'b0, AW'(255 - a), '0, q);
      check(q == shadow[255 - a], "R3 read other address", q, shadow[255 - a]);
    end

    // Retention while idle
    ret_req = 1'b1;
    @(negedge clk);
    check(!req_ready, "R7 ready low on retention", req_ready, 0);
    @(negedge clk);
    check(ret_ack && mem_cs_n, "R7 parked", {ret_ack, mem_cs_n}, 3);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(mem_cs_n && !req_ready, "R7 held deselected", {mem_cs_n, req_ready}, 2);
    end
    ret_req = 1'b0;
    n = 0;
    @(negedge clk);
    while (!req_ready && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == RC_EXP, "R8 blocked cycles after release", n, RC_EXP);

    // Retention raised during a write
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h3C; req_wdata = 8'h99;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ret_req = 1'b1;
    while (!rsp_valid) @(negedge clk);
    check(rsp_write, "R7 in-flight write completes", rsp_write, 1);
    shadow[8'h3C] = 8'h99;
    @(negedge clk);
    check(ret_ack && mem_cs_n, "R7 parked after access", {ret_ack, mem_cs_n}, 3);
    ret_req = 1'b0;
    @(negedge clk);
    access(1'b0, 8'h3C, '0, q);
    check(q == 8'h99, "R7 write data kept", q, 8'h99);
    access(1'b0, 8'h00, '0, q);
    check(q == shadow[0], "R3 read after retention", q, shadow[0]);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule